// File: doc/BRIEF.md
# Row-Aware DRAM Read Scheduler

This block orders read requests for a single DRAM channel with four banks. Requests arrive through a valid/ready port. Each one carries a bank index, a row index and a small thread tag. They wait in an eight-entry queue that is kept in age order. Each cycle the scheduler works out which command every queued request needs next: a precharge, an activate, or a read. It checks that against per-bank timers and a shared data-bus timer. It then issues at most one command on the command/address bus.

Every command holds its bank for 10 cycles. Reads that hit the row already open in a bank may be spaced 5 cycles apart. Each read moves a 64-byte burst over the data bus for the 5 cycles after its bank occupancy ends. When a burst completes, the block reports the thread tag and the current cycle count.

A mode input picks the policy. In plain first-come mode, only the oldest request may be served. In row-hit-first mode, a request that can be read from an open row is served ahead of older requests that need the row changed. Among equals, the oldest wins.

Top module: `dram_sched`

## Requirements
- R1: After reset the queue is empty, `req_ready_o` is 1, `cmd_valid_o` and `done_valid_o` are 0, and every bank counts as closed. The first command to any bank is therefore a precharge.
- R2: Command codes on `cmd_type_o` are 1 = precharge, 2 = activate and 3 = read. A request whose bank is closed or has another row open receives precharge, activate and read, in that order, to its bank. A request to the open row of its bank receives one read only.
- R3: After any command to a bank, no further command goes to that bank for 10 cycles. The one exception is a read that follows a read to the same open row, which may come 5 cycles after it.
- R4: Two reads, to any banks, are at least 5 cycles apart on the command bus, so data bursts never overlap.
- R5: `done_valid_o` pulses with the request's tag exactly 15 cycles after its read appears on the command bus. `done_time_o` equals the number of clock edges since reset was released.
- R6: With all timers expired, a request accepted at edge E completes at edge E+36 if its bank needs a row change. It completes at E+16 if it hits the open row.
- R7: With `mode_i` = 0, only the oldest queued request receives commands, even when a younger one targets an idle bank with its row open.
- R8: With `mode_i` = 1, a ready read to an open row is issued before any older request's precharge or activate. Among ready requests of the same kind, the oldest is served first.
- R9: The queue holds 8 requests. A request is taken on an edge with `req_valid_i` and `req_ready_o` both high, and `req_ready_o` is 0 while 8 requests wait.
- R10: With `mode_i` = 0, completions leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one cycle per nanosecond of DRAM time |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = oldest-only, 1 = row-hit-first |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Queue has room |
| req_bank_i | input | 2 | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_tid_i | input | TID_W | Thread tag |
| cmd_valid_o | output | 1 | Command on the command bus this cycle |
| cmd_type_o | output | 2 | 1 precharge, 2 activate, 3 read |
| cmd_bank_o | output | 2 | Command bank |
| cmd_row_o | output | ROW_W | Command row |
| done_valid_o | output | 1 | A read burst has just finished |
| done_tid_o | output | TID_W | Tag of the finished request |
| done_time_o | output | TIME_W | Cycle count at completion |

## Verification
A wrong open-row record shows up on the command bus at the next command to that bank. The bank either gets a spurious precharge or a read with no activate before it. A timer that is off by one moves a command one cycle early or late, and the completion time of every later request shifts with it. A wrong age order or a wrong mode decision shows as completion tags in the wrong order, tens of cycles before the queue drains.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PRE  = 2'd1,
    CMD_ACT  = 2'd2,
    CMD_RD   = 2'd3
  } cmd_e;
endpackage

// File: rtl/dsch_queue.sv
module dsch_queue #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8,
  parameter int TID_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [BANK_W-1:0] push_bank_i,
  input  logic [ROW_W-1:0]  push_row_i,
  input  logic [TID_W-1:0]  push_tid_i,
  input  logic              pop_i,
  input  logic [$clog2(DEPTH)-1:0] pop_idx_i,
  output logic [DEPTH-1:0]  vld_o,
  output logic [BANK_W-1:0] bank_o [DEPTH],
  output logic [ROW_W-1:0]  row_o [DEPTH],
  output logic [TID_W-1:0]  tid_o [DEPTH],
  output logic              full_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [BANK_W-1:0] bank_q [DEPTH];
  logic [BANK_W-1:0] bank_d [DEPTH];
  logic [ROW_W-1:0]  row_q  [DEPTH];
  logic [ROW_W-1:0]  row_d  [DEPTH];
  logic [TID_W-1:0]  tid_q  [DEPTH];
  logic [TID_W-1:0]  tid_d  [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  // index 0 is always the oldest entry; a pop compacts the entries above it
  always_comb begin
    bank_d = bank_q;
    row_d  = row_q;
    tid_d  = tid_q;
    cnt_d  = cnt_q;
    if (pop_i) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(pop_idx_i)) begin
          bank_d[i] = bank_q[i+1];
          row_d[i]  = row_q[i+1];
          tid_d[i]  = tid_q[i+1];
        end
      end
      cnt_d = cnt_q - CNT_W'(1);
    end
    if (push_i) begin
      bank_d[cnt_d[IDX_W-1:0]] = push_bank_i;
      row_d[cnt_d[IDX_W-1:0]]  = push_row_i;
      tid_d[cnt_d[IDX_W-1:0]]  = push_tid_i;
      cnt_d = cnt_d + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i) begin
    bank_q <= bank_d;
    row_q  <= row_d;
    tid_q  <= tid_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_vld
    assign vld_o[g]  = cnt_q > CNT_W'(g);
    assign bank_o[g] = bank_q[g];
    assign row_o[g]  = row_q[g];
    assign tid_o[g]  = tid_q[g];
  end

  assign full_o = cnt_q == CNT_W'(DEPTH);
endmodule

// File: rtl/dsch_bank.sv
module dsch_bank #(
  parameter int ROW_W  = 8,
  parameter int T_BUSY = 10,
  parameter int T_HIT  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_i,
  input  logic             act_i,
  input  logic             rd_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic             prech_o,
  output logic [ROW_W-1:0] row_o,
  output logic             busy_ok_o,
  output logic             rd_ok_o
);
  localparam int CW = $clog2(T_BUSY + 1);

  logic [CW-1:0] busy_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= '0;
      rd_q    <= '0;
      open_o  <= 1'b0;
      prech_o <= 1'b0;
      row_o   <= '0;
    end else begin
      if (pre_i || act_i || rd_i) busy_q <= CW'(T_BUSY - 1);
      else if (busy_q != '0)      busy_q <= busy_q - CW'(1);

      if (rd_i)                 rd_q <= CW'(T_HIT - 1);
      else if (pre_i || act_i)  rd_q <= CW'(T_BUSY - 1);
      else if (rd_q != '0)      rd_q <= rd_q - CW'(1);

      if (pre_i) begin
        open_o  <= 1'b0;
        prech_o <= 1'b1;
      end
      if (act_i) begin
        open_o  <= 1'b1;
        prech_o <= 1'b0;
        row_o   <= row_i;
      end
    end
  end

  assign busy_ok_o = busy_q == '0;
  assign rd_ok_o   = rd_q == '0;
endmodule

// File: rtl/dsch_picker.sv
module dsch_picker
  import dram_sched_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8
) (
  input  logic              mode_i,
  input  logic [DEPTH-1:0]  vld_i,
  input  logic [BANK_W-1:0] bank_i [DEPTH],
  input  logic [ROW_W-1:0]  row_i [DEPTH],
  input  logic [NBANK-1:0]  open_i,
  input  logic [NBANK-1:0]  prech_i,
  input  logic [ROW_W-1:0]  orow_i [NBANK],
  input  logic [NBANK-1:0]  busy_ok_i,
  input  logic [NBANK-1:0]  rd_ok_i,
  input  logic              bus_ok_i,
  output logic              issue_o,
  output logic [$clog2(DEPTH)-1:0] idx_o,
  output cmd_e              cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] hit, rdy;
  logic [NBANK-1:0] bank_hit;
  cmd_e             need [DEPTH];
  logic             hit_found;
  logic [IDX_W-1:0] hit_idx;

  always_comb begin
    bank_hit = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit[i] = vld_i[i] && open_i[bank_i[i]] && (orow_i[bank_i[i]] == row_i[i]);
      if (hit[i]) bank_hit[bank_i[i]] = 1'b1;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i])                need[i] = CMD_RD;
      else if (prech_i[bank_i[i]]) need[i] = CMD_ACT;
      else                       need[i] = CMD_PRE;
      // in hit-first mode a row with pending hits is not closed under them
      rdy[i] = vld_i[i] && (hit[i] ? (rd_ok_i[bank_i[i]] && bus_ok_i)
                                   : (busy_ok_i[bank_i[i]] &&
                                      !(mode_i && need[i] == CMD_PRE && bank_hit[bank_i[i]])));
    end
  end

  always_comb begin
    issue_o   = 1'b0;
    idx_o     = '0;
    hit_found = 1'b0;
    hit_idx   = '0;
    if (!mode_i) begin
      issue_o = rdy[0];
    end else begin
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (rdy[i]) begin
          issue_o = 1'b1;
          idx_o   = IDX_W'(i);
        end
        if (rdy[i] && hit[i]) begin
          hit_found = 1'b1;
          hit_idx   = IDX_W'(i);
        end
      end
      if (hit_found) idx_o = hit_idx;
    end
    cmd_o  = need[idx_o];
    bank_o = bank_i[idx_o];
    row_o  = row_i[idx_o];
  end
endmodule

// File: rtl/dsch_done_pipe.sv
module dsch_done_pipe #(
  parameter int LAT   = 16,
  parameter int TID_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [TID_W-1:0] tid_i,
  output logic             vld_o,
  output logic [TID_W-1:0] tid_o
);
  logic [LAT-1:0]   vld_q;
  logic [TID_W-1:0] tid_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], vld_i};
  end

  always_ff @(posedge clk_i) begin
    tid_q[0] <= tid_i;
    for (int i = 1; i < LAT; i++) tid_q[i] <= tid_q[i-1];
  end

  assign vld_o = vld_q[LAT-1];
  assign tid_o = tid_q[LAT-1];
endmodule

// File: rtl/dram_sched.sv
module dram_sched
  import dram_sched_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int NBANK   = 4,
  parameter int ROW_W   = 8,
  parameter int TID_W   = 2,
  parameter int TIME_W  = 32,
  parameter int T_BUSY  = 10,
  parameter int T_HIT   = 5,
  parameter int T_BURST = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mode_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [$clog2(NBANK)-1:0] req_bank_i,
  input  logic [ROW_W-1:0]         req_row_i,
  input  logic [TID_W-1:0]         req_tid_i,
  output logic                     cmd_valid_o,
  output logic [1:0]               cmd_type_o,
  output logic [$clog2(NBANK)-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]         cmd_row_o,
  output logic                     done_valid_o,
  output logic [TID_W-1:0]         done_tid_o,
  output logic [TIME_W-1:0]        done_time_o
);
  localparam int BANK_W   = $clog2(NBANK);
  localparam int IDX_W    = $clog2(DEPTH);
  localparam int DONE_LAT = T_BUSY + T_BURST + 1;
  localparam int BUS_W    = $clog2(T_BURST + 1);

  logic [DEPTH-1:0]  q_vld;
  logic [BANK_W-1:0] q_bank [DEPTH];
  logic [ROW_W-1:0]  q_row  [DEPTH];
  logic [TID_W-1:0]  q_tid  [DEPTH];
  logic              q_full;

  logic [NBANK-1:0]  b_open, b_prech, b_busy_ok, b_rd_ok;
  logic [ROW_W-1:0]  b_row [NBANK];

  logic              sel_issue;
  logic [IDX_W-1:0]  sel_idx;
  cmd_e              sel_cmd;
  logic [BANK_W-1:0] sel_bank;
  logic [ROW_W-1:0]  sel_row;
  logic              sel_rd;

  logic [BUS_W-1:0]  bus_q;
  logic [TIME_W-1:0] now_q;
  logic              push;

  assign push        = req_valid_i && !q_full;
  assign req_ready_o = !q_full;
  assign sel_rd      = sel_issue && (sel_cmd == CMD_RD);

  dsch_queue #(
    .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .TID_W(TID_W)
  ) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_bank_i (req_bank_i),
    .push_row_i  (req_row_i),
    .push_tid_i  (req_tid_i),
    .pop_i       (sel_rd),
    .pop_idx_i   (sel_idx),
    .vld_o       (q_vld),
    .bank_o      (q_bank),
    .row_o       (q_row),
    .tid_o       (q_tid),
    .full_o      (q_full)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit_me;
    assign hit_me = sel_issue && (sel_bank == BANK_W'(b));
    dsch_bank #(
      .ROW_W(ROW_W), .T_BUSY(T_BUSY), .T_HIT(T_HIT)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pre_i     (hit_me && sel_cmd == CMD_PRE),
      .act_i     (hit_me && sel_cmd == CMD_ACT),
      .rd_i      (hit_me && sel_cmd == CMD_RD),
      .row_i     (sel_row),
      .open_o    (b_open[b]),
      .prech_o   (b_prech[b]),
      .row_o     (b_row[b]),
      .busy_ok_o (b_busy_ok[b]),
      .rd_ok_o   (b_rd_ok[b])
    );
  end

  dsch_picker #(
    .DEPTH(DEPTH), .NBANK(NBANK), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_pick (
    .mode_i    (mode_i),
    .vld_i     (q_vld),
    .bank_i    (q_bank),
    .row_i     (q_row),
    .open_i    (b_open),
    .prech_i   (b_prech),
    .orow_i    (b_row),
    .busy_ok_i (b_busy_ok),
    .rd_ok_i   (b_rd_ok),
    .bus_ok_i  (bus_q == '0),
    .issue_o   (sel_issue),
    .idx_o     (sel_idx),
    .cmd_o     (sel_cmd),
    .bank_o    (sel_bank),
    .row_o     (sel_row)
  );

  dsch_done_pipe #(
    .LAT(DONE_LAT), .TID_W(TID_W)
  ) u_done (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (sel_rd),
    .tid_i  (q_tid[sel_idx]),
    .vld_o  (done_valid_o),
    .tid_o  (done_tid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_type_o  <= 2'd0;
      cmd_bank_o  <= '0;
      cmd_row_o   <= '0;
      bus_q       <= '0;
      now_q       <= '0;
    end else begin
      cmd_valid_o <= sel_issue;
      cmd_type_o  <= sel_issue ? sel_cmd : CMD_NONE;
      cmd_bank_o  <= sel_bank;
      cmd_row_o   <= sel_row;
      now_q       <= now_q + TIME_W'(1);
      if (sel_rd)            bus_q <= BUS_W'(T_BURST - 1);
      else if (bus_q != '0)  bus_q <= bus_q - BUS_W'(1);
    end
  end

  assign done_time_o = now_q;
endmodule

// File: rtl/dram_sched_chk.sv
module dram_sched_chk #(
  parameter int DEPTH   = 8,
  parameter int NBANK   = 4,
  parameter int BANK_W  = 2,
  parameter int T_BUSY  = 10,
  parameter int T_HIT   = 5,
  parameter int T_BURST = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              cmd_valid_o,
  input logic [1:0]        cmd_type_o,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic              done_valid_o
);
  localparam int LAG = T_BUSY + T_BURST;

  logic          rd_now, acc;
  logic [7:0]    since_rd;
  logic          rd_seen;
  logic [LAG-1:0] hist_q;
  logic [7:0]    occ_q;
  logic [7:0]    since_b [NBANK];
  logic [1:0]    last_b  [NBANK];

  assign rd_now = cmd_valid_o && cmd_type_o == 2'd3;
  assign acc    = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rd <= '0;
      rd_seen  <= 1'b0;
      hist_q   <= '0;
      occ_q    <= '0;
      for (int b = 0; b < NBANK; b++) begin
        since_b[b] <= '0;
        last_b[b]  <= 2'd0;
      end
    end else begin
      hist_q <= {hist_q[LAG-2:0], rd_now};
      occ_q  <= occ_q + 8'(acc) - 8'(rd_now);
      if (rd_now) begin
        since_rd <= 8'd1;
        rd_seen  <= 1'b1;
      end else if (since_rd != 8'hff) since_rd <= since_rd + 8'd1;
      for (int b = 0; b < NBANK; b++) begin
        if (cmd_valid_o && cmd_bank_o == BANK_W'(b)) begin
          since_b[b] <= 8'd1;
          last_b[b]  <= cmd_type_o;
        end else if (since_b[b] != 8'hff) since_b[b] <= since_b[b] + 8'd1;
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank_chk
    a_r2_cmd_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_o && cmd_bank_o == BANK_W'(b)) |->
        ((cmd_type_o == 2'd1 && last_b[b] != 2'd1) ||
         (cmd_type_o == 2'd2 && last_b[b] == 2'd1) ||
         (cmd_type_o == 2'd3 && (last_b[b] == 2'd2 || last_b[b] == 2'd3))));

    a_r3_bank_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_o && cmd_bank_o == BANK_W'(b)) |->
        (last_b[b] == 2'd0 || since_b[b] >= 8'(T_BUSY) ||
         (cmd_type_o == 2'd3 && last_b[b] == 2'd3 && since_b[b] >= 8'(T_HIT))));
  end

  a_r4_bus_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_now |-> (!rd_seen || since_rd >= 8'(T_BURST)));

  a_r5_done_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |-> hist_q[LAG-1]);

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q - 8'(rd_now)) <= 8'(DEPTH));

  a_r9_ready_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o == ((occ_q - 8'(rd_now)) < 8'(DEPTH)));
endmodule

bind dram_sched dram_sched_chk #(
  .DEPTH(DEPTH), .NBANK(NBANK), .BANK_W(BANK_W),
  .T_BUSY(T_BUSY), .T_HIT(T_HIT), .T_BURST(T_BURST)
) u_chk (.*);

// File: tb/dram_sched_tb.sv
module dram_sched_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_bank = '0;
  logic [7:0] req_row = '0;
  logic [1:0] req_tid = '0;
  logic       cmd_valid;
  logic [1:0] cmd_type;
  logic [1:0] cmd_bank;
  logic [7:0] cmd_row;
  logic       done_valid;
  logic [1:0] done_tid;
  logic [31:0] done_time;

  dram_sched u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_tid_i(req_tid),
    .cmd_valid_o(cmd_valid), .cmd_type_o(cmd_type), .cmd_bank_o(cmd_bank), .cmd_row_o(cmd_row),
    .done_valid_o(done_valid), .done_tid_o(done_tid), .done_time_o(done_time)
  );

  always #5ns clk = ~clk;

  typedef struct packed {
    logic [1:0] bank;
    logic [7:0] row;
    logic [1:0] tid;
    logic [7:0] lat;
    logic [1:0] ncmd;
  } vec_t;

  // serial requests, each on an idle channel: closed/conflict 36, hit 16
  localparam vec_t VECS [8] = '{
    '{2'd0, 8'd5, 2'd0, 8'd36, 2'd3},
    '{2'd0, 8'd5, 2'd1, 8'd16, 2'd1},
    '{2'd0, 8'd7, 2'd2, 8'd36, 2'd3},
    '{2'd1, 8'd7, 2'd3, 8'd36, 2'd3},
    '{2'd0, 8'd7, 2'd0, 8'd16, 2'd1},
    '{2'd1, 8'd2, 2'd1, 8'd36, 2'd3},
    '{2'd3, 8'd0, 2'd2, 8'd36, 2'd3},
    '{2'd3, 8'd0, 2'd3, 8'd16, 2'd1}
  };

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int cmd_total = 0;
  int done_n = 0;
  int done_cyc [64];
  logic [1:0] done_tq [64];
  logic [1:0] last_cmd = 2'd0;
  logic [1:0] first_cmd = 2'd0;
  logic [15:0] rd_hist = '0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_valid) begin
        done_cyc[done_n % 64] = cyc;
        done_tq[done_n % 64]  = done_tid;
        done_n++;
        chk(done_time == 32'(cyc), "R5 done_time", done_time, cyc);
        chk(rd_hist[14], "R5 read 15 cycles earlier", rd_hist[14], 1);
      end
      rd_hist = {rd_hist[14:0], cmd_valid && cmd_type == 2'd3};
      if (cmd_valid) begin
        if (cmd_total == 0) first_cmd = cmd_type;
        cmd_total++;
        last_cmd = cmd_type;
      end
    end
  end

  task automatic push(input logic [1:0] b, input logic [7:0] r, input logic [1:0] t, output int acc);
    req_valid = 1'b1;
    req_bank = b;
    req_row = r;
    req_tid = t;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int target);
    int guard = 0;
    while (done_n < target && guard < 600) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=drained");
    finish_run();
  end

  initial begin
    int acc_a, acc_b, d0, c0;
    int acc_f [8];
    // R1: reset state
    idle(3);
    chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    chk(cmd_valid == 1'b0, "R1 no cmd in reset", cmd_valid, 0);
    chk(done_valid == 1'b0, "R1 no done in reset", done_valid, 0);
    rst_n = 1'b1;
    idle(2);
    chk(cmd_valid == 1'b0 && req_ready, "R1 idle after reset", cmd_valid, 0);

    // table walk: R2, R6
    mode = 1'b1;
    for (int v = 0; v < 8; v++) begin
      d0 = done_n;
      c0 = cmd_total;
      push(VECS[v].bank, VECS[v].row, VECS[v].tid, acc_a);
      wait_done(d0 + 1);
      chk(done_cyc[d0 % 64] - acc_a == int'(VECS[v].lat), "R6 latency",
          done_cyc[d0 % 64] - acc_a, VECS[v].lat);
      chk(done_tq[d0 % 64] == VECS[v].tid, "R5 tag", done_tq[d0 % 64], VECS[v].tid);
      chk(cmd_total - c0 == int'(VECS[v].ncmd), "R2 command count",
          cmd_total - c0, VECS[v].ncmd);
      chk(last_cmd == 2'd3, "R2 ends with read", last_cmd, 3);
      if (v == 0) chk(first_cmd == 2'd1, "R1 first command precharge", first_cmd, 1);
      idle(4);
    end

    // R3: pipelined hits to the same open row, 5 apart
    d0 = done_n;
    push(2'd3, 8'd0, 2'd1, acc_a);
    push(2'd3, 8'd0, 2'd2, acc_b);
    wait_done(d0 + 2);
    chk(done_cyc[d0 % 64] - acc_a == 16, "R3 first hit", done_cyc[d0 % 64] - acc_a, 16);
    chk(done_cyc[(d0 + 1) % 64] - acc_a == 21, "R3 second hit 5 later",
        done_cyc[(d0 + 1) % 64] - acc_a, 21);
    idle(20);

    // R4: hits on two banks share the data bus
    d0 = done_n;
    push(2'd0, 8'd7, 2'd0, acc_a);
    push(2'd3, 8'd0, 2'd3, acc_b);
    wait_done(d0 + 2);
    chk(done_cyc[(d0 + 1) % 64] - done_cyc[d0 % 64] == 5, "R4 bursts 5 apart",
        done_cyc[(d0 + 1) % 64] - done_cyc[d0 % 64], 5);
    chk(done_tq[(d0 + 1) % 64] == 2'd3, "R4 second tag", done_tq[(d0 + 1) % 64], 3);
    idle(20);

    // R7: oldest-only mode, younger hit waits behind a miss
    mode = 1'b0;
    d0 = done_n;
    push(2'd1, 8'd9, 2'd0, acc_a);
    push(2'd0, 8'd7, 2'd1, acc_b);
    wait_done(d0 + 2);
    chk(done_tq[d0 % 64] == 2'd0, "R7 oldest first", done_tq[d0 % 64], 0);
    chk(done_cyc[d0 % 64] - acc_a == 36, "R7 miss latency", done_cyc[d0 % 64] - acc_a, 36);
    chk(done_cyc[(d0 + 1) % 64] - acc_a == 41, "R7 hit held back",
        done_cyc[(d0 + 1) % 64] - acc_a, 41);
    idle(20);

    // R8: hit-first mode, younger hit overtakes
    mode = 1'b1;
    d0 = done_n;
    push(2'd1, 8'd3, 2'd2, acc_a);
    push(2'd0, 8'd7, 2'd3, acc_b);
    wait_done(d0 + 2);
    chk(done_tq[d0 % 64] == 2'd3, "R8 hit overtakes", done_tq[d0 % 64], 3);
    chk(done_cyc[d0 % 64] - acc_a == 17, "R8 hit latency", done_cyc[d0 % 64] - acc_a, 17);
    chk(done_cyc[(d0 + 1) % 64] - acc_a == 36, "R8 miss latency",
        done_cyc[(d0 + 1) % 64] - acc_a, 36);
    idle(20);

    // R9, R10: fill the queue with conflicting rows on one bank
    mode = 1'b0;
    d0 = done_n;
    for (int i = 0; i < 8; i++) push(2'd2, (i % 2 == 0) ? 8'd1 : 8'd2, 2'(i), acc_f[i]);
    req_valid = 1'b1;
    req_bank = 2'd2;
    req_row = 8'd3;
    chk(req_ready == 1'b0, "R9 full after 8", req_ready, 0);
    @(negedge clk);
    chk(req_ready == 1'b0, "R9 still full", req_ready, 0);
    req_valid = 1'b0;
    wait_done(d0 + 8);
    chk(done_n - d0 == 8, "R9 all eight complete", done_n - d0, 8);
    chk(done_cyc[d0 % 64] - acc_f[0] == 36, "R6 first of full queue",
        done_cyc[d0 % 64] - acc_f[0], 36);
    chk(done_cyc[(d0 + 1) % 64] - done_cyc[d0 % 64] == 30, "R3 conflict spacing",
        done_cyc[(d0 + 1) % 64] - done_cyc[d0 % 64], 30);
    for (int i = 0; i < 8; i++)
      chk(done_tq[(d0 + i) % 64] == 2'(i), "R10 completion order", done_tq[(d0 + i) % 64], i % 4);
    idle(5);
    chk(req_ready == 1'b1, "R9 ready after drain", req_ready, 1);

    finish_run();
  end
endmodule